// File: doc/BRIEF.md
# Memory Field and Interrupt Controller

This block keeps the three-bit field registers of a 12-bit processor with a 15-bit (32K-word) address space. It also runs the machine's single interrupt-enable system. The registers are the instruction field, the data field, a buffered next instruction field and a six-bit saved field. The CPU presents each fetched instruction together with a fetch strobe. In that cycle the block decides whether an interrupt is taken. If one is, it hands back a forced subroutine call to address 0 in place of the fetched word. If not, it executes the I/O-transfer instructions aimed at the interrupt system (device 00) or at the field logic (devices 20 to 27).

The CPU reports each completed jump or subroutine call on a strobe. This strobe commits a buffered instruction-field change. Interrupts stay inhibited from the field-change instruction until that commit, so a handler can never be entered between the two. The block also forms the 15-bit instruction address from the program counter and the 15-bit indirect operand address from a 12-bit pointer word.

Top module: `mfic_top`

## Requirements
- R1: While rst_ni is low, all field registers, the saved field, interrupt enable, inhibit and pending change read as zero, and force_int_o, skip_o and ac_load_o are low.
- R2: iaddr_o is {ifield_o, pc_i} and daddr_o is {dfield_o, ptr_i}, combinationally, in every cycle.
- R3: An executed 6001 (octal) sets interrupt enable and 6002 clears it, visible from the next cycle.
- R4: An executed 6003 raises skip_o in its fetch cycle exactly when interrupt enable is set, and changes no state.
- R5: In a fetch cycle an interrupt is taken (force_int_o high, instr_o = 4000 octal) only if irq_i is high, enable is set, inhibit is clear and the previous fetch was not itself a taken interrupt. Otherwise instr_o equals instr_i and force_int_o is low.
- R6: A taken interrupt loads the saved field with {IF, DF} (IF in bits 5:3), clears IF, DF and enable, and suppresses execution of the instruction on instr_i.
- R7: An executed 62N1 (N = instruction bits 5:3) loads DF with N.
- R8: An executed 62N2 loads the buffered field with N and sets both the pending-change and inhibit flags, leaving IF unchanged.
- R9: jump_done_i in a cycle with a change pending copies the buffered field into IF and clears pending and inhibit. Without a pending change it alters nothing.
- R10: An executed 6214, 6224 or 6234 raises ac_load_o for its fetch cycle with ac_val_o = DF<<3, IF<<3 or the saved field, respectively. At all other times ac_load_o is low and ac_val_o is zero.
- R11: An executed 6244 loads the buffered field from saved bits 5:3 and DF from saved bits 2:0. It does not set pending.
- R12: I/O-transfer words with function code other than 1, 2 or 4 on devices 20 to 27, with function 4 on device 20 or 25 to 27, on other device codes, and any word presented while fetch_i is low change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_i | input | 1 | instr_i holds a freshly fetched word this cycle |
| instr_i | input | 12 | Fetched instruction word |
| irq_i | input | 1 | Level interrupt request |
| jump_done_i | input | 1 | A JMP or JMS completed this cycle |
| pc_i | input | 12 | Program counter |
| ptr_i | input | 12 | Indirect pointer word |
| instr_o | output | 12 | Instruction to execute (forced call when interrupting) |
| force_int_o | output | 1 | Interrupt taken in this fetch |
| skip_o | output | 1 | Skip request for the CPU |
| ac_load_o | output | 1 | Load accumulator with ac_val_o |
| ac_val_o | output | 12 | Accumulator load value |
| ifield_o | output | 3 | Instruction field |
| dfield_o | output | 3 | Data field |
| ibuf_o | output | 3 | Buffered instruction field |
| sfield_o | output | 6 | Saved field {IF, DF} |
| ien_o | output | 1 | Interrupt enable |
| inhibit_o | output | 1 | Interrupt inhibit |
| pend_o | output | 1 | Instruction-field change pending |
| iaddr_o | output | 15 | Instruction address |
| daddr_o | output | 15 | Indirect operand address |

## Verification
The bench raises a request while a field change is pending. A design that ignored the inhibit would enter the handler with a half-switched field and lose the return field. It takes an interrupt with a disable word on instr_i. If the forced call did not suppress that word, enable and state would be altered twice. It issues a jump strobe with and without a pending change, which exposes a design that copies the buffer into IF on every jump. It also sends the near-miss codes (function 3, function 4 on device 20 and 25, other device numbers). These catch a decoder that tests function bits one at a time instead of matching the whole code, since such a decoder would corrupt DF or the buffered field.

// File: rtl/mfic_pkg.sv
package mfic_pkg;
  localparam int unsigned WORD_W  = 12;
  localparam int unsigned FIELD_W = 3;
  localparam int unsigned SAVE_W  = 2 * FIELD_W;

  localparam logic [2:0] OP_IOT     = 3'o6;
  localparam logic [5:0] DEV_IRQ    = 6'o00;
  localparam logic [2:0] DEV_FIELD  = 3'o2;
  localparam logic [WORD_W-1:0] INT_INSTR = 12'o4000;

  typedef struct packed {
    logic ion;
    logic iof;
    logic skon;
    logic cdf;
    logic cif;
    logic rdf;
    logic rif;
    logic rib;
    logic rmf;
    logic [FIELD_W-1:0] fld;
  } iot_dec_t;
endpackage

// File: rtl/mfic_iot_dec.sv
module mfic_iot_dec
  import mfic_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         valid_i,
  input  logic [W-1:0] instr_i,
  output iot_dec_t     dec_o
);
  logic       is_iot;
  logic [5:0] dev;
  logic [2:0] fn;
  logic       irq_dev, fld_dev;

  assign is_iot  = valid_i && (instr_i[11:9] == OP_IOT);
  assign dev     = instr_i[8:3];
  assign fn      = instr_i[2:0];
  assign irq_dev = is_iot && (dev == DEV_IRQ);
  assign fld_dev = is_iot && (dev[5:3] == DEV_FIELD);

  always_comb begin
    dec_o      = '0;
    dec_o.fld  = instr_i[5:3];
    dec_o.ion  = irq_dev && (fn == 3'd1);
    dec_o.iof  = irq_dev && (fn == 3'd2);
    dec_o.skon = irq_dev && (fn == 3'd3);
    dec_o.cdf  = fld_dev && (fn == 3'd1);
    dec_o.cif  = fld_dev && (fn == 3'd2);
    if (fld_dev && fn == 3'd4) begin
      unique case (dev[2:0])
        3'd1: dec_o.rdf = 1'b1;
        3'd2: dec_o.rif = 1'b1;
        3'd3: dec_o.rib = 1'b1;
        3'd4: dec_o.rmf = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mfic_irq_ctrl.sv
module mfic_irq_ctrl
  import mfic_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     fetch_i,
  input  logic     irq_i,
  input  iot_dec_t dec_i,
  input  logic     commit_i,
  output logic     take_o,
  output logic     skip_o,
  output logic     ien_o,
  output logic     inhibit_o
);
  logic ien_q, inh_q, last_int_q;

  assign take_o    = fetch_i && irq_i && ien_q && !inh_q && !last_int_q;
  assign skip_o    = dec_i.skon && ien_q;
  assign ien_o     = ien_q;
  assign inhibit_o = inh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q      <= 1'b0;
      last_int_q <= 1'b0;
    end else if (take_o) begin
      ien_q      <= 1'b0;
      last_int_q <= 1'b1;
    end else begin
      if (fetch_i)        last_int_q <= 1'b0;
      if (dec_i.ion)      ien_q      <= 1'b1;
      else if (dec_i.iof) ien_q      <= 1'b0;
    end
  end

  // inhibit spans field-change instruction up to the committing jump
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          inh_q <= 1'b0;
    else if (dec_i.cif)   inh_q <= 1'b1;
    else if (commit_i)    inh_q <= 1'b0;
  end
endmodule

// File: rtl/mfic_field_regs.sv
module mfic_field_regs
  import mfic_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned FW = FIELD_W,
  localparam int unsigned SW = 2 * FW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  iot_dec_t      dec_i,
  input  logic          jump_done_i,
  output logic          commit_o,
  output logic [FW-1:0] if_o,
  output logic [FW-1:0] df_o,
  output logic [FW-1:0] ib_o,
  output logic [SW-1:0] sf_o,
  output logic          pend_o,
  output logic          ac_load_o,
  output logic [W-1:0]  ac_val_o
);
  logic [FW-1:0] if_q, df_q, ib_q;
  logic [SW-1:0] sf_q;
  logic          pend_q;

  assign commit_o = jump_done_i && pend_q && !take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      if_q <= '0;
      df_q <= '0;
      ib_q <= '0;
      sf_q <= '0;
    end else if (take_i) begin
      sf_q <= {if_q, df_q};
      if_q <= '0;
      df_q <= '0;
    end else begin
      if (commit_o)  if_q <= ib_q;
      if (dec_i.cdf) df_q <= dec_i.fld;
      if (dec_i.cif) ib_q <= dec_i.fld;
      if (dec_i.rmf) begin
        ib_q <= sf_q[SW-1:FW];
        df_q <= sf_q[FW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (dec_i.cif) pend_q <= 1'b1;
    else if (commit_o)  pend_q <= 1'b0;
  end

  always_comb begin
    ac_val_o = '0;
    if (dec_i.rdf) ac_val_o = W'({df_q, {FW{1'b0}}});
    if (dec_i.rif) ac_val_o = W'({if_q, {FW{1'b0}}});
    if (dec_i.rib) ac_val_o = W'(sf_q);
  end
  assign ac_load_o = dec_i.rdf || dec_i.rif || dec_i.rib;

  assign if_o   = if_q;
  assign df_o   = df_q;
  assign ib_o   = ib_q;
  assign sf_o   = sf_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/mfic_top.sv
module mfic_top
  import mfic_pkg::*;
#(
  parameter int unsigned WORD_BITS  = WORD_W,
  parameter int unsigned FIELD_BITS = FIELD_W,
  localparam int unsigned ADDR_BITS = WORD_BITS + FIELD_BITS,
  localparam int unsigned SAVE_BITS = 2 * FIELD_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fetch_i,
  input  logic [WORD_BITS-1:0]  instr_i,
  input  logic                  irq_i,
  input  logic                  jump_done_i,
  input  logic [WORD_BITS-1:0]  pc_i,
  input  logic [WORD_BITS-1:0]  ptr_i,
  output logic [WORD_BITS-1:0]  instr_o,
  output logic                  force_int_o,
  output logic                  skip_o,
  output logic                  ac_load_o,
  output logic [WORD_BITS-1:0]  ac_val_o,
  output logic [FIELD_BITS-1:0] ifield_o,
  output logic [FIELD_BITS-1:0] dfield_o,
  output logic [FIELD_BITS-1:0] ibuf_o,
  output logic [SAVE_BITS-1:0]  sfield_o,
  output logic                  ien_o,
  output logic                  inhibit_o,
  output logic                  pend_o,
  output logic [ADDR_BITS-1:0]  iaddr_o,
  output logic [ADDR_BITS-1:0]  daddr_o
);
  logic     take, exec, commit;
  iot_dec_t dec;

  assign exec = fetch_i && !take;

  mfic_iot_dec #(.W(WORD_BITS)) u_dec (
    .valid_i (exec),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  mfic_irq_ctrl u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fetch_i   (fetch_i),
    .irq_i     (irq_i),
    .dec_i     (dec),
    .commit_i  (commit),
    .take_o    (take),
    .skip_o    (skip_o),
    .ien_o     (ien_o),
    .inhibit_o (inhibit_o)
  );

  mfic_field_regs #(.W(WORD_BITS), .FW(FIELD_BITS)) u_fld (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .dec_i       (dec),
    .jump_done_i (jump_done_i),
    .commit_o    (commit),
    .if_o        (ifield_o),
    .df_o        (dfield_o),
    .ib_o        (ibuf_o),
    .sf_o        (sfield_o),
    .pend_o      (pend_o),
    .ac_load_o   (ac_load_o),
    .ac_val_o    (ac_val_o)
  );

  assign force_int_o = take;
  assign instr_o     = take ? INT_INSTR : instr_i;
  assign iaddr_o     = {ifield_o, pc_i};
  assign daddr_o     = {dfield_o, ptr_i};
endmodule

// File: rtl/mfic_chk.sv
module mfic_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        jump_done_i,
  input logic [11:0] instr_o,
  input logic        force_int_o,
  input logic        skip_o,
  input logic        ac_load_o,
  input logic [2:0]  ifield_o,
  input logic [2:0]  dfield_o,
  input logic [2:0]  ibuf_o,
  input logic [5:0]  sfield_o,
  input logic        ien_o,
  input logic        inhibit_o,
  input logic        pend_o
);
  // R5
  forced_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_int_o |-> instr_o == 12'o4000);
  // R5
  take_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_int_o |-> ien_o && !inhibit_o);
  // R6
  take_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_int_o |=> ifield_o == 3'd0 && dfield_o == 3'd0 && !ien_o);
  // R6
  take_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_int_o |=> sfield_o == {$past(ifield_o), $past(dfield_o)});
  // R4
  skip_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> ien_o && !force_int_o);
  // R8
  pend_inh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> inhibit_o);
  // R9
  commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_done_i && pend_o |=> ifield_o == $past(ibuf_o));
  // R10
  acload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ac_load_o |-> !force_int_o && !skip_o);
endmodule

bind mfic_top mfic_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .jump_done_i (jump_done_i),
  .instr_o     (instr_o),
  .force_int_o (force_int_o),
  .skip_o      (skip_o),
  .ac_load_o   (ac_load_o),
  .ifield_o    (ifield_o),
  .dfield_o    (dfield_o),
  .ibuf_o      (ibuf_o),
  .sfield_o    (sfield_o),
  .ien_o       (ien_o),
  .inhibit_o   (inhibit_o),
  .pend_o      (pend_o)
);

// File: tb/mfic_top_tb_top.sv
module mfic_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch = 1'b0;
  logic [11:0] instr = '0;
  logic        irq = 1'b0;
  logic        jd = 1'b0;
  logic [11:0] pc = '0;
  logic [11:0] ptr = '0;
  logic [11:0] instr_o, ac_val;
  logic        force_int, skip, ac_load, ien, inh, pend;
  logic [2:0]  ifld, dfld, ibuf;
  logic [5:0]  sfld;
  logic [14:0] iaddr, daddr;

  int checks = 0;
  int failures = 0;

  // reference state
  int m_if = 0, m_df = 0, m_ib = 0, m_sf = 0;
  int m_ien = 0, m_inh = 0, m_pend = 0, m_last = 0;

  always #5 clk = ~clk;

  mfic_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_i(fetch), .instr_i(instr),
    .irq_i(irq), .jump_done_i(jd), .pc_i(pc), .ptr_i(ptr),
    .instr_o(instr_o), .force_int_o(force_int), .skip_o(skip),
    .ac_load_o(ac_load), .ac_val_o(ac_val), .ifield_o(ifld),
    .dfield_o(dfld), .ibuf_o(ibuf), .sfield_o(sfld), .ien_o(ien),
    .inhibit_o(inh), .pend_o(pend), .iaddr_o(iaddr), .daddr_o(daddr)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0o expected=%0o", tag, what, act, exp);
    end
  endtask

  // one clock: drive, compare combinational and state outputs, step model
  task automatic step(input string tag, input bit f, input int ins, input bit rq,
                      input bit j, input int p = 12'o0200, input int q = 12'o0010);
    int dv, fn, take, exe, iot, e_ac, e_ld, e_sk;
    int o_if, o_df, o_ib, o_sf, o_pend;
    fetch = f; instr = 12'(ins); irq = rq; jd = j; pc = 12'(p); ptr = 12'(q);
    #1;
    dv   = (ins >> 3) & 6'o77;
    fn   = ins & 7;
    take = (f && rq && m_ien && !m_inh && !m_last) ? 1 : 0;
    exe  = (f && !take) ? 1 : 0;
    iot  = (exe && ((ins >> 9) & 7) == 6) ? 1 : 0;
    e_ld = 0; e_ac = 0;
    if (iot && (dv >> 3) == 2 && fn == 4) begin
      if ((dv & 7) == 1) begin e_ld = 1; e_ac = m_df << 3; end
      if ((dv & 7) == 2) begin e_ld = 1; e_ac = m_if << 3; end
      if ((dv & 7) == 3) begin e_ld = 1; e_ac = m_sf; end
    end
    e_sk = (iot && dv == 0 && fn == 3 && m_ien) ? 1 : 0;
    chk("R5", "force_int_o", int'(force_int), take);
    chk("R5", "instr_o", int'(instr_o), take ? 12'o4000 : ins);
    chk("R4", "skip_o", int'(skip), e_sk);
    chk("R10", "ac_load_o", int'(ac_load), e_ld);
    chk("R10", "ac_val_o", int'(ac_val), e_ac);
    chk("R2", "iaddr_o", int'(iaddr), (m_if << 12) | p);
    chk("R2", "daddr_o", int'(daddr), (m_df << 12) | q);
    chk(tag, "ifield_o", int'(ifld), m_if);
    chk(tag, "dfield_o", int'(dfld), m_df);
    chk(tag, "ibuf_o", int'(ibuf), m_ib);
    chk(tag, "sfield_o", int'(sfld), m_sf);
    chk(tag, "ien_o", int'(ien), m_ien);
    chk(tag, "inhibit_o", int'(inh), m_inh);
    chk(tag, "pend_o", int'(pend), m_pend);
    @(posedge clk);
    o_if = m_if; o_df = m_df; o_ib = m_ib; o_sf = m_sf; o_pend = m_pend;
    if (take) begin
      m_sf = (o_if << 3) | o_df; m_if = 0; m_df = 0; m_ien = 0; m_last = 1;
    end else begin
      if (f) m_last = 0;
      if (j && o_pend) begin m_if = o_ib; m_pend = 0; m_inh = 0; end
      if (iot && dv == 0 && fn == 1) m_ien = 1;
      if (iot && dv == 0 && fn == 2) m_ien = 0;
      if (iot && (dv >> 3) == 2) begin
        if (fn == 1) m_df = (ins >> 3) & 7;
        if (fn == 2) begin m_ib = (ins >> 3) & 7; m_pend = 1; m_inh = 1; end
        if (fn == 4 && (dv & 7) == 4) begin m_ib = o_sf >> 3; m_df = o_sf & 7; end
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: state during reset
    #12;
    chk("R1", "ifield_o", int'(ifld), 0);
    chk("R1", "dfield_o", int'(dfld), 0);
    chk("R1", "sfield_o", int'(sfld), 0);
    chk("R1", "ien_o", int'(ien), 0);
    chk("R1", "pend_o", int'(pend), 0);
    chk("R1", "force_int_o", int'(force_int), 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R2: address forming with zero fields
    step("R2", 0, 0, 0, 0, 12'o7777, 12'o1234);
    step("R2", 1, 12'o7000, 0, 0, 12'o0001, 12'o4321);
    // R7: data field loads
    step("R7", 1, 12'o6231, 0, 0);
    step("R7", 1, 12'o6271, 0, 0, 12'o0100, 12'o7777);
    // R12: near-miss codes and non-fetch words
    step("R12", 1, 12'o6203, 0, 0);
    step("R12", 1, 12'o6204, 0, 0);
    step("R12", 1, 12'o6254, 0, 0);
    step("R12", 1, 12'o6104, 0, 0);
    step("R12", 1, 12'o6005, 0, 0);
    step("R12", 0, 12'o6252, 0, 0);
    step("R12", 0, 12'o6001, 0, 0);
    // R9: jump without pending change
    step("R9", 0, 0, 0, 1);
    // R8: buffered field change
    step("R8", 1, 12'o6252, 0, 0);
    step("R8", 0, 0, 0, 0);
    // R3: enable while inhibited
    step("R3", 1, 12'o6001, 0, 0);
    // R5: request blocked by inhibit
    step("R5", 1, 12'o7000, 1, 0);
    step("R5", 1, 12'o6003, 1, 0);
    // R9: commit
    step("R9", 0, 0, 1, 1);
    step("R2", 0, 0, 0, 0, 12'o0345, 12'o0006);
    // R10: reads
    step("R10", 1, 12'o6214, 0, 0);
    step("R10", 1, 12'o6224, 0, 0);
    step("R10", 1, 12'o6234, 0, 0);
    // R5/R6: take with a disable word on instr_i
    step("R5", 0, 12'o6002, 1, 0);
    step("R6", 1, 12'o6002, 1, 0);
    step("R6", 1, 12'o7000, 1, 0);
    step("R10", 1, 12'o6234, 0, 0);
    // R4: skip with enable off then on
    step("R4", 1, 12'o6003, 0, 0);
    step("R3", 1, 12'o6001, 0, 0);
    step("R4", 1, 12'o6003, 0, 0);
    step("R3", 1, 12'o6002, 0, 0);
    step("R5", 1, 12'o7000, 1, 0);
    // R11: restore from saved field
    step("R7", 1, 12'o6211, 0, 0);
    step("R11", 1, 12'o6244, 0, 0);
    step("R11", 0, 0, 0, 0);
    step("R9", 0, 0, 0, 1);
    // second interrupt from a nonzero field
    step("R8", 1, 12'o6232, 0, 0);
    step("R9", 0, 0, 0, 1);
    step("R7", 1, 12'o6261, 0, 0);
    step("R3", 1, 12'o6001, 0, 0);
    step("R6", 1, 12'o1234, 1, 0);
    step("R6", 1, 12'o1234, 1, 0);
    step("R10", 1, 12'o6234, 0, 0);
    step("R11", 1, 12'o6244, 0, 0);
    step("R11", 1, 12'o6214, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule